// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Divider

This block is the feedback divider of a fractional-N frequency synthesizer. It runs on the high-speed clock and contains a digital model of a dual-modulus prescaler that divides by 16 or by 17. A main counter of N prescaler cycles sets the output period. A swallow counter selects the divide-by-17 modulus for the first cycles of each period. One output pulse per period goes to the phase comparator. Over time the periods average 16·N + A + F/13 input cycles.

The fraction comes from an accumulator with a fixed modulus of 13. At every period boundary it adds F. When the sum reaches 13, the accumulator wraps and the period that starts there swallows one extra cycle (A + 1). Settings are written with a load strobe and held in a pending register. They become active only at the next period boundary, so a count in progress is never disturbed. Illegal values are clamped when they are captured and are reported on an error output.

Top module: `fnd_divider`

## Requirements
- R1: `divPulse` is high for exactly one clock cycle per output period. With F = 0 and constant settings, consecutive pulses are 16·N + A cycles apart.
- R2: `modCtl` is high for the first 17·S cycles of every period and low for the rest, where S is that period's swallow count (A, or A + 1 on a wrap). It rises only at the start of a period.
- R3: Any 13 consecutive periods under one setting last 13·(16·N + A) + F input cycles in total.
- R4: The modulo-13 accumulator holds a value from 0 to 12. Every period lasts either 16·N + A or 16·N + A + 1 cycles, and exactly F of any 13 consecutive periods are the longer kind.
- R5: After reset the active setting is N = 18, A = 0, F = 0, and `divPulse`, `modCtl` and `cfgErr` are low. The first full period lasts 288 cycles.
- R6: A load takes effect at the first period boundary after its capture edge. The period running when the load arrives keeps its old length, and the active setting never changes mid-count.
- R7: A loaded N below 18 is replaced by 18, and a loaded F of 13 or more is replaced by 12. `cfgErr` shows, from the cycle after the capture edge, whether the most recent load held such a value.
- R8: Every A from 0 to 15 is accepted. With A = 0 and F = 0, `modCtl` stays low throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed input clock (prescaler input) |
| rstN | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Captures nIn, aIn, fIn on this rising edge |
| nIn | input | 10 | Main counter ratio N, legal range 18 to 1023 |
| aIn | input | 4 | Swallow count A, 0 to 15 |
| fIn | input | 4 | Fraction numerator F, legal range 0 to 12 |
| divPulse | output | 1 | One-cycle pulse at the start of each output period |
| modCtl | output | 1 | Modulus control: 1 selects divide-by-17, 0 divide-by-16 |
| cfgErr | output | 1 | The last load was out of range and has been clamped |

## Verification
`cfgErr` settles one cycle after the edge that captures a load, so the bench reads it at the next falling edge. `divPulse` rises in the first cycle of a period, one register after the last prescaler tick. Period lengths are therefore measured pulse to pulse, and the cycle count for `modCtl` runs from one pulse cycle up to the cycle before the next. A new setting is measured only from the first pulse after its load, because only that period uses it. The R6 check times the period in progress when the load lands against the old ratio. Inputs are driven and outputs sampled on falling edges only.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  // control -> datapath
  typedef struct packed {
    logic capture;   // take nIn/aIn/fIn into the pending register
    logic commit;    // period boundary: load counters, step accumulator
    logic step;      // prescaler tick inside a period
    logic usePend;   // pending setting is newer than the active one
  } fndStrb_t;

  // datapath -> control
  typedef struct packed {
    logic psTick;    // prescaler finishes a 16/17 cycle
    logic mainLast;  // main counter on its final prescaler cycle
  } fndStat_t;
endpackage

// File: rtl/fnd_ctrl.sv
module fnd_ctrl
  import fnd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     load,
  input  fndStat_t stat,
  output fndStrb_t strb,
  output logic     divPulse
);
  logic pendValid;
  logic boundary;

  assign boundary     = stat.psTick && stat.mainLast;
  assign strb.capture = load;
  assign strb.commit  = boundary;
  assign strb.step    = stat.psTick && !stat.mainLast;
  assign strb.usePend = pendValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      divPulse  <= 1'b0;
    end else begin
      divPulse <= boundary;
      if (load)          pendValid <= 1'b1;
      else if (boundary) pendValid <= 1'b0;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse); // R1
endmodule

// File: rtl/fnd_datapath.sv
module fnd_datapath
  import fnd_pkg::*;
#(
  parameter int NW   = 10,
  parameter int AW   = 4,
  parameter int FW   = 4,
  parameter int P    = 16,
  parameter int Q    = 13,
  parameter int NMIN = 18
) (
  input  logic          clk,
  input  logic          rstN,
  input  fndStrb_t      strb,
  input  logic [NW-1:0] nIn,
  input  logic [AW-1:0] aIn,
  input  logic [FW-1:0] fIn,
  output fndStat_t      stat,
  output logic          modCtl,
  output logic          cfgErr
);
  localparam int PSW  = $clog2(P + 1);
  localparam int SWW  = AW + 1;
  localparam int QW   = $clog2(Q);
  localparam int SUMW = ((QW > FW) ? QW : FW) + 1;

  logic [NW-1:0]   pendN, actN, selN, nClamp;
  logic [AW-1:0]   pendA, actA, selA;
  logic [FW-1:0]   pendF, actF, selF, fClamp;
  logic            badCfg;
  logic [QW-1:0]   acc, accNext;
  logic [SUMW-1:0] sum;
  logic            carry;
  logic [NW-1:0]   mainCnt;
  logic [SWW-1:0]  swCnt, swDec, nextSw;
  logic [PSW-1:0]  psCnt;

  // clamp at capture
  always_comb begin
    nClamp = (int'(nIn) < NMIN) ? NW'(NMIN) : nIn;
    fClamp = (int'(fIn) >= Q) ? FW'(Q - 1) : fIn;
    badCfg = (int'(nIn) < NMIN) || (int'(fIn) >= Q);
  end

  assign selN = strb.usePend ? pendN : actN;
  assign selA = strb.usePend ? pendA : actA;
  assign selF = strb.usePend ? pendF : actF;
  assign sum  = SUMW'(acc) + SUMW'(selF);

  generate
    if ((Q & (Q - 1)) == 0) begin : g_pow2Wrap
      always_comb begin
        carry   = sum[QW];
        accNext = sum[QW-1:0];
      end
    end else begin : g_cmpWrap
      always_comb begin
        carry   = (sum >= SUMW'(Q));
        accNext = carry ? QW'(sum - SUMW'(Q)) : QW'(sum);
      end
    end
  endgenerate

  assign nextSw = SWW'(selA) + SWW'(carry);
  assign swDec  = (swCnt != '0) ? swCnt - SWW'(1) : swCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendN  <= NW'(NMIN);
      pendA  <= '0;
      pendF  <= '0;
      cfgErr <= 1'b0;
    end else if (strb.capture) begin
      pendN  <= nClamp;
      pendA  <= aIn;
      pendF  <= fClamp;
      cfgErr <= badCfg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actN    <= NW'(NMIN);
      actA    <= '0;
      actF    <= '0;
      acc     <= '0;
      mainCnt <= NW'(NMIN);
      swCnt   <= '0;
      psCnt   <= PSW'(P - 1);
    end else if (strb.commit) begin
      actN    <= selN;
      actA    <= selA;
      actF    <= selF;
      acc     <= accNext;
      mainCnt <= selN;
      swCnt   <= nextSw;
      psCnt   <= (nextSw != '0) ? PSW'(P) : PSW'(P - 1);
    end else if (strb.step) begin
      mainCnt <= mainCnt - NW'(1);
      swCnt   <= swDec;
      psCnt   <= (swDec != '0) ? PSW'(P) : PSW'(P - 1);
    end else begin
      psCnt   <= psCnt - PSW'(1);
    end
  end

  assign stat.psTick   = (psCnt == '0);
  assign stat.mainLast = (mainCnt == NW'(1));
  assign modCtl        = (swCnt != '0);

  AST_ACC_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(acc) < Q); // R4
  AST_SW_WITHIN_MAIN: assert property (@(posedge clk) disable iff (!rstN)
    SWW'(swCnt) <= SWW'(mainCnt) || mainCnt > NW'((1 << SWW) - 1)); // R2
  AST_MOD_RISE_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modCtl) |-> $past(strb.commit)); // R2
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(actN) && $stable(actA) && $stable(actF))); // R6
  AST_CLAMP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (int'(actN) >= NMIN) && (int'(actF) < Q)); // R7
endmodule

// File: rtl/fnd_divider.sv
module fnd_divider
  import fnd_pkg::*;
#(
  parameter int NW   = 10,
  parameter int AW   = 4,
  parameter int FW   = 4,
  parameter int P    = 16,
  parameter int Q    = 13,
  parameter int NMIN = 18
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic [NW-1:0] nIn,
  input  logic [AW-1:0] aIn,
  input  logic [FW-1:0] fIn,
  output logic          divPulse,
  output logic          modCtl,
  output logic          cfgErr
);
  fndStrb_t strb;
  fndStat_t stat;

  fnd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .load(load),
    .stat(stat), .strb(strb), .divPulse(divPulse)
  );

  fnd_datapath #(
    .NW(NW), .AW(AW), .FW(FW), .P(P), .Q(Q), .NMIN(NMIN)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .nIn(nIn), .aIn(aIn), .fIn(fIn),
    .stat(stat), .modCtl(modCtl), .cfgErr(cfgErr)
  );
endmodule

// File: tb/fnd_divider_bench.sv
module fnd_divider_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       load = 1'b0;
  logic [9:0] nIn = '0;
  logic [3:0] aIn = '0;
  logic [3:0] fIn = '0;
  logic       divPulse, modCtl, cfgErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cyc    = 0;

  fnd_divider u_fnd_divider (
    .clk(clk), .rstN(rstN), .load(load), .nIn(nIn), .aIn(aIn), .fIn(fIn),
    .divPulse(divPulse), .modCtl(modCtl), .cfgErr(cfgErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doLoad(input int n, input int a, input int f);
    nIn  = 10'(n);
    aIn  = 4'(a);
    fIn  = 4'(f);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic waitPulse();
    do @(negedge clk); while (!divPulse);
  endtask

  // starts at a pulse cycle, ends at the next pulse cycle
  task automatic measure(output int len, output int modCnt);
    len = 0;
    modCnt = 0;
    do begin
      if (modCtl) modCnt++;
      len++;
      @(negedge clk);
    end while (!divPulse && len < 20000);
  endtask

  task automatic runCfg(input int n, input int a, input int f, input int expErr);
    int en, ef, base, sum, mods, longs, odd, len, m;
    doLoad(n, a, f);
    chk("R7 cfgErr after load", int'(cfgErr), expErr);
    en = (n < 18) ? 18 : n;
    ef = (f >= 13) ? 12 : f;
    base = 16 * en + a;
    waitPulse();
    sum = 0; mods = 0; longs = 0; odd = 0;
    for (int i = 0; i < 13; i++) begin
      measure(len, m);
      if (i == 0 && f == 0) chk("R1 period length", len, base);
      sum += len;
      mods += m;
      if (len == base + 1) longs++;
      else if (len != base) odd++;
    end
    chk("R3 13-period total", sum, 13 * base + ef);
    chk("R4 periods of other length", odd, 0);
    chk("R4 long periods", longs, ef);
    chk("R2 modCtl cycles", mods, 17 * (13 * a + ef));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int len, m, t0;
    repeat (3) @(negedge clk);
    chk("R5 divPulse in reset", int'(divPulse), 0);
    chk("R5 modCtl in reset", int'(modCtl), 0);
    chk("R5 cfgErr in reset", int'(cfgErr), 0);
    rstN = 1'b1;
    waitPulse();
    measure(len, m);
    chk("R5 first period", len, 288);
    chk("R8 modCtl idle with A=0", m, 0);

    // near-exhaustive sweep of the fraction
    for (int f = 0; f < 13; f++) runCfg(18, 5, f, 0);
    runCfg(19, 0, 7, 0);
    runCfg(25, 15, 12, 0);   // R8 largest A
    runCfg(40, 3, 1, 0);
    runCfg(18, 0, 0, 0);     // R8 A=0 keeps modCtl low
    runCfg(5, 2, 14, 1);     // R7 both fields clamped
    runCfg(30, 7, 0, 0);     // R7 flag clears

    // R6: load mid-period, old length completes first
    doLoad(18, 0, 0);
    waitPulse();
    waitPulse();
    t0 = cyc;
    repeat (40) @(negedge clk);
    doLoad(20, 4, 0);
    waitPulse();
    chk("R6 running period keeps old ratio", cyc - t0, 288);
    measure(len, m);
    chk("R6 new ratio from next boundary", len, 324);
    chk("R2 modCtl cycles single period", m, 68);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule